// File: doc/BRIEF.md
# Fully Associative Read Cache with Rank-Based LRU Replacement

This block is a small read cache that sits between a requester and a slower backing memory. Any address may be placed in any of its lines, so every lookup compares the requested address against all stored tags at once. A hit returns the stored word in the same cycle as the request. A miss starts a fill from memory. The requester keeps its request and address steady until it sees `cpu_ready`.

Each line carries its full address as a tag, a valid flag, one data word and a small recency rank. The ranks always form a permutation of 0..N-1. N-1 marks the most recently used line and 0 the least recently used one. When a line is touched, by a hit or by a fill, its rank goes to N-1. Every line whose rank was above the touched line's old rank moves down by one. A fill uses a free line while one remains. Once all lines are valid, it replaces the line ranked 0.

Control is a two-state machine. In `ST_LOOKUP` the cache answers hits and moves to `ST_FILL` on a miss. In `ST_FILL` it holds `mem_req` high, stays in `ST_FILL` while `mem_ack` is low, and returns to `ST_LOOKUP` in the cycle `mem_ack` arrives. It then forwards `mem_rdata` to the requester in that same cycle.

Top module: `lru_assoc_cache`

## Requirements
- R1: After reset all lines are invalid, `mem_req` and `cpu_ready` are low, and the ranks hold a permutation of 0..N-1, so the first request after reset is a miss.
- R2: A request whose address matches a valid tag in `ST_LOOKUP` raises `cpu_ready` in the same cycle with `cpu_rdata` equal to the stored word, while `mem_req` stays low; at most one line matches any address.
- R3: A request that matches no valid tag keeps `cpu_ready` low in its cycle; from the next cycle `mem_req` is high with `mem_addr` equal to the requested address, and both stay unchanged, with `cpu_ready` low, until `mem_ack` is seen.
- R4: In the cycle `mem_ack` is high during a fill, `cpu_ready` is high and `cpu_rdata` equals `mem_rdata`; the word is stored under the requested address, `mem_req` is low in the following cycle, and a later request to that address hits.
- R5: A fill goes to the lowest-numbered invalid line while any line is invalid, so the first N distinct addresses all remain resident; that free line always carries rank 0.
- R6: A touched line (hit or fill) receives rank N-1, every line ranked above its previous rank is decremented by one, the rest keep their rank, and the ranks stay a permutation.
- R7: When every line is valid, a fill replaces the line with rank 0, which is the least recently used address.
- R8: A hit refreshes recency, so the address just hit is not the one replaced by the next fill while other resident lines are older.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Read request, held until `cpu_ready` |
| cpu_addr | input | AW | Requested address, held with `cpu_req` |
| cpu_ready | output | 1 | Read data valid this cycle |
| cpu_rdata | output | DW | Returned word |
| mem_req | output | 1 | Fill request to backing memory |
| mem_addr | output | AW | Fill address |
| mem_ack | input | 1 | Memory returns the fill word this cycle |
| mem_rdata | input | DW | Fill word from memory |

## Verification
A hit is a combinational result: `cpu_ready` and `cpu_rdata` are due in the request cycle itself, so the bench samples 1 ns after it drives the request on the falling edge, before any rising edge passes. `mem_req` and `mem_addr` come from the state register and are due one rising edge after the missing request. The fill response is due in the `mem_ack` cycle, so it is sampled 1 ns after `mem_ack` is driven. The drop of `mem_req` is checked one edge after the acknowledge. Replacement order (R5 to R8) is observed only through later hit or miss outcomes, which the bench predicts from its own timestamp-based LRU model.

// File: rtl/lru_cache_pkg.sv
package lru_cache_pkg;

    typedef enum logic [0:0] {
        ST_LOOKUP = 1'b0,
        ST_FILL   = 1'b1
    } cache_state_e;

endpackage

// File: rtl/lru_tag_match.sv
module lru_tag_match #(
    parameter int N  = 4,
    parameter int AW = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [AW-1:0]        lookup_addr,
    input  logic [N-1:0]         line_valid,
    input  logic [N-1:0][AW-1:0] line_tag,
    output logic [N-1:0]         hit_vec,
    output logic                 any_hit,
    output logic [IW-1:0]        hit_idx
);

    // one comparator per line, all in parallel
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = line_valid[g] && (line_tag[g] == lookup_addr);
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                hit_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]         line_valid,
    input  logic [N-1:0][IW-1:0] line_rank,
    output logic [IW-1:0]        victim_idx
);

    logic free_found;

    // lowest-numbered free line first, otherwise the rank-0 line
    always_comb begin
        victim_idx = '0;
        free_found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!line_valid[i] && !free_found) begin
                victim_idx = IW'(i);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int i = 0; i < N; i++) begin
                if (line_rank[i] == '0) begin
                    victim_idx = IW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/lru_rank_update.sv
module lru_rank_update #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0][IW-1:0] line_rank,
    input  logic [IW-1:0]        touch_idx,
    output logic [N-1:0][IW-1:0] rank_next
);

    localparam logic [IW-1:0] RANK_TOP = IW'(N - 1);

    logic [IW-1:0] touched_old;

    assign touched_old = line_rank[touch_idx];

    for (genvar g = 0; g < N; g++) begin : g_rank
        always_comb begin
            if (touch_idx == IW'(g)) begin
                rank_next[g] = RANK_TOP;
            end else if (line_rank[g] > touched_old) begin
                rank_next[g] = line_rank[g] - IW'(1);
            end else begin
                rank_next[g] = line_rank[g];
            end
        end
    end

endmodule

// File: rtl/lru_assoc_cache.sv
module lru_assoc_cache
    import lru_cache_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    output logic          cpu_ready,
    output logic [DW-1:0] cpu_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    localparam int IW = $clog2(N);

    // line storage
    logic [N-1:0]         line_valid;
    logic [N-1:0][AW-1:0] line_tag;
    logic [N-1:0][DW-1:0] line_data;
    logic [N-1:0][IW-1:0] line_rank;
    logic [N-1:0][IW-1:0] rank_next;

    // control
    cache_state_e  state, state_nx;
    logic [AW-1:0] fill_addr;
    logic          in_fill;
    logic [N-1:0]  hit_vec;
    logic          any_hit;
    logic [IW-1:0] hit_idx;
    logic [IW-1:0] victim_idx;
    logic          lookup_hit;
    logic          miss_start;
    logic          fill_done;
    logic          touch_en;
    logic [IW-1:0] touch_idx;

    lru_tag_match #(.N(N), .AW(AW)) u_match (
        .lookup_addr (cpu_addr),
        .line_valid  (line_valid),
        .line_tag    (line_tag),
        .hit_vec     (hit_vec),
        .any_hit     (any_hit),
        .hit_idx     (hit_idx)
    );

    lru_victim_pick #(.N(N)) u_victim (
        .line_valid (line_valid),
        .line_rank  (line_rank),
        .victim_idx (victim_idx)
    );

    lru_rank_update #(.N(N)) u_rank (
        .line_rank (line_rank),
        .touch_idx (touch_idx),
        .rank_next (rank_next)
    );

    assign in_fill    = (state == ST_FILL);
    assign lookup_hit = !in_fill && cpu_req && any_hit;
    assign miss_start = !in_fill && cpu_req && !any_hit;
    assign fill_done  = in_fill && mem_ack;
    assign touch_en   = lookup_hit || fill_done;
    assign touch_idx  = fill_done ? victim_idx : hit_idx;
    assign mem_addr   = fill_addr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOOKUP;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOOKUP: if (miss_start) state_nx = ST_FILL;
            ST_FILL:   if (mem_ack)    state_nx = ST_LOOKUP;
        endcase
    end

    // outputs
    always_comb begin
        cpu_ready = 1'b0;
        cpu_rdata = '0;
        mem_req   = 1'b0;
        unique case (state)
            ST_LOOKUP: begin
                if (cpu_req && any_hit) begin
                    cpu_ready = 1'b1;
                    cpu_rdata = line_data[hit_idx];
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    cpu_rdata = mem_rdata;
                end
            end
        endcase
    end

    // line storage and recency ranks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_addr  <= '0;
            line_valid <= '0;
            line_tag   <= '0;
            line_data  <= '0;
            for (int i = 0; i < N; i++) begin
                line_rank[i] <= IW'(i);
            end
        end else begin
            if (miss_start) begin
                fill_addr <= cpu_addr;
            end
            if (touch_en) begin
                line_rank <= rank_next;
            end
            if (fill_done) begin
                line_valid[victim_idx] <= 1'b1;
                line_tag[victim_idx]   <= fill_addr;
                line_data[victim_idx]  <= mem_rdata;
            end
        end
    end

endmodule

// File: rtl/lru_cache_checker.sv
module lru_cache_checker #(
    parameter int N  = 4,
    parameter int AW = 16,
    localparam int IW = $clog2(N)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_fill,
    input logic                 mem_req,
    input logic                 mem_ack,
    input logic [AW-1:0]        mem_addr,
    input logic                 cpu_ready,
    input logic [N-1:0]         line_valid,
    input logic [N-1:0][IW-1:0] line_rank,
    input logic [N-1:0]         hit_vec,
    input logic                 touch_en,
    input logic [IW-1:0]        touch_idx,
    input logic [IW-1:0]        victim_idx
);

    logic [N-1:0] rank_seen;

    always_comb begin
        rank_seen = '0;
        for (int i = 0; i < N; i++) begin
            rank_seen[line_rank[i]] = 1'b1;
        end
    end

    assert_rank_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        &rank_seen);

    assert_touch_mru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> line_rank[$past(touch_idx)] == IW'(N - 1));

    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_free_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fill && mem_ack && !(&line_valid)) |->
            (!line_valid[victim_idx] && line_rank[victim_idx] == '0));

    assert_evict_lru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fill && mem_ack && (&line_valid)) |-> line_rank[victim_idx] == '0);

    assert_fill_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_wait_no_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |-> !cpu_ready);

    assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

endmodule

bind lru_assoc_cache lru_cache_checker #(.N(N), .AW(AW)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_fill    (in_fill),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .cpu_ready  (cpu_ready),
    .line_valid (line_valid),
    .line_rank  (line_rank),
    .hit_vec    (hit_vec),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
);

// File: tb/lru_assoc_cache_bench.sv
module lru_assoc_cache_bench;

    localparam int N  = 4;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_req;
    logic [AW-1:0] cpu_addr;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    // reference model: timestamp-based true LRU
    logic [AW-1:0] m_tag   [N];
    bit            m_valid [N];
    int            m_stamp [N];
    int            now_t = 0;

    always #4 clk = ~clk;

    lru_assoc_cache #(.N(N), .AW(AW), .DW(DW)) u_lru_assoc_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_addr  (cpu_addr),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return DW'(a * 16'h9e37) ^ 16'h5a5a;
    endfunction

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++) begin
            if (m_valid[i] && m_tag[i] == a) return i;
        end
        return -1;
    endfunction

    function automatic int m_victim();
        int v = 0;
        for (int i = 0; i < N; i++) begin
            if (!m_valid[i]) return i;
        end
        for (int i = 1; i < N; i++) begin
            if (m_stamp[i] < m_stamp[v]) v = i;
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    // one read; starts just after a falling edge, ends on one
    task automatic access(input logic [AW-1:0] a, input int lat, input string lbl);
        int idx;
        int v;
        idx = m_find(a);
        cpu_req  = 1'b1;
        cpu_addr = a;
        #1;
        if (idx >= 0) begin
            check(cpu_ready == 1'b1, lbl, 32'(cpu_ready), 32'd1);
            check(cpu_rdata == mem_word(a), "R2", 32'(cpu_rdata), 32'(mem_word(a)));
            check(mem_req == 1'b0, "R2", 32'(mem_req), 32'd0);
            now_t++;
            m_stamp[idx] = now_t;
            @(negedge clk);
            cpu_req = 1'b0;
        end else begin
            check(cpu_ready == 1'b0, lbl, 32'(cpu_ready), 32'd0);
            @(negedge clk);
            #1;
            check(mem_req == 1'b1, "R3", 32'(mem_req), 32'd1);
            check(mem_addr == a, "R3", 32'(mem_addr), 32'(a));
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                #1;
                check(mem_req == 1'b1 && cpu_ready == 1'b0, "R3",
                      {30'd0, mem_req, cpu_ready}, 32'd2);
                check(mem_addr == a, "R3", 32'(mem_addr), 32'(a));
            end
            mem_ack   = 1'b1;
            mem_rdata = mem_word(a);
            #1;
            check(cpu_ready == 1'b1, "R4", 32'(cpu_ready), 32'd1);
            check(cpu_rdata == mem_word(a), "R4", 32'(cpu_rdata), 32'(mem_word(a)));
            v = m_victim();
            m_valid[v] = 1'b1;
            m_tag[v]   = a;
            now_t++;
            m_stamp[v] = now_t;
            @(negedge clk);
            mem_ack   = 1'b0;
            mem_rdata = '0;
            cpu_req   = 1'b0;
            #1;
            check(mem_req == 1'b0, "R4", 32'(mem_req), 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!reported) begin
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            report();
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] pick;
        void'($urandom(32'd7741));
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0;
            m_tag[i]   = '0;
            m_stamp[i] = 0;
        end
        rst_n     = 1'b0;
        cpu_req   = 1'b0;
        cpu_addr  = '0;
        mem_ack   = 1'b0;
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(mem_req == 1'b0, "R1", 32'(mem_req), 32'd0);
        check(cpu_ready == 1'b0, "R1", 32'(cpu_ready), 32'd0);

        // first request after reset must miss
        cpu_req  = 1'b1;
        cpu_addr = 16'h1000;
        #1;
        check(cpu_ready == 1'b0, "R1", 32'(cpu_ready), 32'd0);
        access(16'h1000, 2, "R1");
        access(16'h1002, 0, "R3");
        access(16'h1004, 1, "R3");
        access(16'h1006, 3, "R3");

        // R5: all four distinct addresses stay resident
        access(16'h1000, 0, "R5");
        access(16'h1002, 0, "R5");
        access(16'h1004, 0, "R5");
        access(16'h1006, 0, "R5");
        access(16'h1000, 0, "R4");

        // R8: refreshed 1000 survives; oldest 1002 is replaced by 2000
        access(16'h2000, 1, "R3");
        access(16'h1000, 0, "R8");
        access(16'h1004, 0, "R7");
        access(16'h1002, 2, "R7");
        // R6: after the chain above 1006 is the oldest and must be gone
        access(16'h1006, 0, "R6");
        access(16'h2000, 0, "R6");

        // random mix over six addresses
        for (int n = 0; n < 400; n++) begin
            pick = 16'h1000 + AW'(2 * ($urandom % 6));
            access(pick, int'($urandom % 4), "R6");
        end

        report();
        $finish;
    end

endmodule